// File: doc/BRIEF.md
# Serial Receive Queue with Fill Threshold

This block holds the characters a serial receiver has assembled until the host collects them. Each stored entry is a data byte plus three error marks: parity, framing and break. The host reads the entry at the head of the queue. It watches a receive-side line status byte. It programs the queue through a write-only control byte. That byte switches queueing on or off, empties the receive or transmit queue once per write, picks a fill threshold and selects the alternate DMA signalling mode.

The block raises a threshold signal for the interrupt logic once the number of stored entries reaches the programmed level. With queueing switched off, the block acts as a single holding register. The deserialiser, the character timeout and the transmit queue itself sit outside the block. The transmit side only receives a one-cycle flush pulse.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, queueing is off, all status bits, `rx_trig`, `tx_flush` and `dma_sel` are 0.
- R2: Bytes leave the queue in arrival order. `rx_head` shows the oldest entry, and a `host_rd_data` pulse removes it at the next edge.
- R3: With queueing on, the queue holds 16 entries. A byte arriving while 16 are stored and no read occurs in that cycle sets overrun (status bit 1). That byte is dropped, and the stored entries stay unchanged.
- R4: The overrun bit stays set until a `host_rd_lsr` pulse, which clears it at the next edge.
- R5: Control bits [7:6] select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. With queueing on, `rx_trig` is high exactly while the number of stored entries is at or above that level.
- R6: A control write with bit 1 set empties the receive queue at the next edge; status bit 0 (data ready) becomes 0. Bit 1 acts only on that write: a later write with bit 1 clear leaves the stored entries in place.
- R7: A control write with bit 2 set gives a one-cycle `tx_flush` pulse in the cycle after the write, and leaves the receive queue untouched.
- R8: Status bits 2, 3 and 4 show the parity, framing and break marks of the head entry, and are 0 when the queue is empty.
- R9: Status bit 7 sets when an entry with any error mark is stored. It stays set while any stored entry carries a mark, and clears at a `host_rd_lsr` pulse that finds no marked entry left.
- R10: With queueing off (control bit 0 = 0), at most one byte is held. A second byte before the read sets overrun and is dropped. `rx_trig` then equals data ready.
- R11: A control write that changes bit 0 empties the receive queue and pulses `tx_flush`. `fifo_on` reports bit 0.
- R12: `dma_sel` equals control bit 3 while queueing is on and is 0 while it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Strobe: a received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error mark of the offered byte |
| rx_ferr | input | 1 | Framing error mark of the offered byte |
| rx_brk | input | 1 | Break mark of the offered byte |
| host_rd_data | input | 1 | Host reads the head entry (removes it) |
| host_rd_lsr | input | 1 | Host reads the line status byte |
| ctl_wr | input | 1 | Strobe: write of the control byte |
| ctl_byte | input | 8 | Control byte value |
| rx_head | output | 8 | Head entry data, 0 when empty |
| rx_lsr | output | 8 | Receive line status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 5-6 zero, 7 error in queue |
| rx_trig | output | 1 | Fill threshold reached |
| tx_flush | output | 1 | One-cycle flush request to the transmit queue |
| fifo_on | output | 1 | Queueing enabled |
| dma_sel | output | 1 | Alternate DMA signalling selected |

## Verification
The bench fills the queue to exactly 16 entries and offers a 17th. A design with an off-by-one full test would either accept the extra byte or overrun one byte early. One that overwrites on overflow would return corrupted data when the queue is drained. Each threshold code is stepped from empty to 14 entries, so a swapped decode or a strict comparison shows up as `rx_trig` rising one entry early or late. The error summary is checked after the marked entry has been read out but before the status read. A design that derives bit 7 only from the head entry, or clears it without the status read, drops the bit early. The single-register mode, the enable toggle and the non-sticky clear bit are probed for a design that keeps a second byte, keeps stale data, or clears again on every write.

// File: rtl/rxq_pkg.sv
// Package: shared entry type and threshold coding for the receive queue.
// Assumes an 8-bit character and a queue of at least 14 entries.
package rxq_pkg;

    localparam int BYTE_W = 8;

    // One stored character with its three error marks.
    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [BYTE_W-1:0] data;
    } rxq_entry_t;

    // Two-bit threshold selection held in control bits [7:6].
    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } rxq_trig_e;

    // Map a threshold code to the number of entries it stands for.
    function automatic int unsigned trig_level(rxq_trig_e code);
        case (code)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctl.sv
// Module: control byte decoder. It holds the enable, threshold and DMA
// mode fields and turns the clear bits into single-cycle actions.
// Assumes ctl_wr is a one-cycle strobe per host write.
module rxq_ctl
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic [7:0] ctl_byte,
    output logic      fifo_en,
    output rxq_trig_e trig_code,
    output logic      dma_en,
    output logic      rx_clear,
    output logic      tx_flush
);
    logic      en_q;
    logic      dma_q;
    rxq_trig_e trig_q;
    logic      flush_q;
    logic      en_change;

    // Detect a write that toggles the enable bit.
    always_comb begin
        en_change = ctl_wr && (ctl_byte[0] != en_q);
    end

    // Receive clear acts in the cycle of the write, no state kept.
    always_comb begin
        rx_clear = ctl_wr && (ctl_byte[1] || en_change);
    end

    // Latch the persistent control fields on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dma_q  <= 1'b0;
            trig_q <= TRIG_ONE;
        end else if (ctl_wr) begin
            en_q   <= ctl_byte[0];
            dma_q  <= ctl_byte[3];
            trig_q <= rxq_trig_e'(ctl_byte[7:6]);
        end
    end

    // Register a one-cycle transmit flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= ctl_wr && (ctl_byte[2] || en_change);
    end

    // Drive the decoded outputs.
    always_comb begin
        fifo_en   = en_q;
        trig_code = trig_q;
        dma_en    = dma_q && en_q;
        tx_flush  = flush_q;
    end

endmodule

// File: rtl/rxq_store.sv
// Module: circular entry store with occupancy count. Capacity is DEPTH
// entries, or one entry when 'single' is high. A clear wins over a push
// in the same cycle. A push into a full store is dropped unless a pop
// frees a slot in that cycle.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          single,
    input  logic          push,
    input  logic          pop,
    input  rxq_entry_t    din,
    output rxq_entry_t    head,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] occ;
    logic [CW-1:0] cap;
    logic          room;

    // Decide which requests take effect this cycle.
    always_comb begin
        cap     = single ? CW'(1) : CW'(DEPTH);
        pop_ok  = pop && (occ != '0) && !clear;
        room    = (occ < cap) || pop_ok;
        push_ok = push && room && !clear;
        drop    = push && !room && !clear;
    end

    // Write an accepted entry into its slot.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Present the head entry, zero when the store is empty.
    always_comb begin
        head  = (occ != '0) ? mem[rd_ptr] : '0;
        count = occ;
    end

endmodule

// File: rtl/rxq_status.sv
// Module: receive line status and threshold. It tracks overrun, the count
// of stored entries that carry an error mark, and the sticky error summary.
// Assumes its push/pop qualifiers come from rxq_store in the same cycle.
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push_ok,
    input  logic          push_err,
    input  logic          pop_ok,
    input  logic          drop,
    input  logic          rd_lsr,
    input  logic          fifo_en,
    input  rxq_trig_e     trig_code,
    input  logic [CW-1:0] count,
    input  rxq_entry_t    head,
    output logic [7:0]    lsr,
    output logic          trig_hit,
    output logic [CW-1:0] err_cnt
);
    logic          ovr_q;
    logic          sum_q;
    logic [CW-1:0] ecnt;
    logic          head_err;
    logic [CW-1:0] level;

    // Classify the head entry and decode the threshold.
    always_comb begin
        head_err = head.perr || head.ferr || head.brk;
        level    = CW'(trig_level(trig_code));
    end

    // Overrun: set on a dropped byte, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ovr_q <= 1'b0;
        else if (drop)   ovr_q <= 1'b1;
        else if (rd_lsr) ovr_q <= 1'b0;
    end

    // Count stored entries that carry an error mark.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ecnt <= '0;
        else begin
            case ({push_ok && push_err, pop_ok && head_err})
                2'b10:   ecnt <= ecnt + 1'b1;
                2'b01:   ecnt <= ecnt - 1'b1;
                default: ecnt <= ecnt;
            endcase
        end
    end

    // Error summary: set on a marked push, cleared by a read finding none.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sum_q <= 1'b0;
        else if (push_ok && push_err)    sum_q <= 1'b1;
        else if (rd_lsr && ecnt == '0)   sum_q <= 1'b0;
    end

    // Assemble status byte and threshold flag.
    always_comb begin
        lsr      = 8'h00;
        lsr[0]   = (count != '0);
        lsr[1]   = ovr_q;
        lsr[2]   = head.perr;
        lsr[3]   = head.ferr;
        lsr[4]   = head.brk;
        lsr[7]   = sum_q;
        trig_hit = fifo_en ? (count >= level) : (count != '0);
        err_cnt  = ecnt;
    end

endmodule

// File: rtl/rxq_top.sv
// Module: receive queue top. It joins the control decoder, the entry store
// and the status logic. Assumes one-cycle host strobes and DEPTH >= 14.
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       host_rd_data,
    input  logic       host_rd_lsr,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_byte,
    output logic [7:0] rx_head,
    output logic [7:0] rx_lsr,
    output logic       rx_trig,
    output logic       tx_flush,
    output logic       fifo_on,
    output logic       dma_sel
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          fifo_en;
    rxq_trig_e     trig_code;
    logic          rx_clear;
    rxq_entry_t    din;
    rxq_entry_t    head;
    logic [CW-1:0] occ;
    logic [CW-1:0] err_cnt;
    logic          push_ok;
    logic          pop_ok;
    logic          drop;

    // Pack the incoming character with its marks.
    always_comb begin
        din.data = rx_data;
        din.perr = rx_perr;
        din.ferr = rx_ferr;
        din.brk  = rx_brk;
    end

    rxq_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_byte (ctl_byte),
        .fifo_en  (fifo_en),
        .trig_code(trig_code),
        .dma_en   (dma_sel),
        .rx_clear (rx_clear),
        .tx_flush (tx_flush)
    );

    rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .single (!fifo_en),
        .push   (rx_valid),
        .pop    (host_rd_data),
        .din    (din),
        .head   (head),
        .count  (occ),
        .push_ok(push_ok),
        .pop_ok (pop_ok),
        .drop   (drop)
    );

    rxq_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .push_ok  (push_ok),
        .push_err (rx_perr || rx_ferr || rx_brk),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .rd_lsr   (host_rd_lsr),
        .fifo_en  (fifo_en),
        .trig_code(trig_code),
        .count    (occ),
        .head     (head),
        .lsr      (rx_lsr),
        .trig_hit (rx_trig),
        .err_cnt  (err_cnt)
    );

    // Expose head data and the enable state.
    always_comb begin
        rx_head = head.data;
        fifo_on = fifo_en;
    end

endmodule

// File: rtl/rxq_chk.sv
// Checker: temporal properties of the receive queue, bound to rxq_top.
module rxq_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          host_rd_data,
    input logic          ctl_wr,
    input logic [7:0]    ctl_byte,
    input logic [7:0]    rx_lsr,
    input logic          rx_trig,
    input logic          tx_flush,
    input logic          fifo_on,
    input logic [CW-1:0] occ,
    input logic [CW-1:0] err_cnt
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    assert_overrun_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && occ == CW'(DEPTH) && rx_valid && !host_rd_data && !ctl_wr)
        |=> (rx_lsr[1] && occ == CW'(DEPTH)));

    assert_trig_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trig |-> rx_lsr[0]);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_byte[1]) |=> !rx_lsr[0]);

    assert_flush_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_byte[2]) |=> tx_flush);

    assert_flush_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> !tx_flush);

    assert_summary_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != '0) |-> rx_lsr[7]);

    assert_single_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> occ <= CW'(1));

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_rxq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .host_rd_data(host_rd_data),
    .ctl_wr      (ctl_wr),
    .ctl_byte    (ctl_byte),
    .rx_lsr      (rx_lsr),
    .rx_trig     (rx_trig),
    .tx_flush    (tx_flush),
    .fifo_on     (fifo_on),
    .occ         (occ),
    .err_cnt     (err_cnt)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic       host_rd_data = 1'b0;
    logic       host_rd_lsr = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_byte = 8'h00;
    logic [7:0] rx_head;
    logic [7:0] rx_lsr;
    logic       rx_trig;
    logic       tx_flush;
    logic       fifo_on;
    logic       dma_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxq_top dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .host_rd_data(host_rd_data), .host_rd_lsr(host_rd_lsr),
        .ctl_wr(ctl_wr), .ctl_byte(ctl_byte), .rx_head(rx_head),
        .rx_lsr(rx_lsr), .rx_trig(rx_trig), .tx_flush(tx_flush),
        .fifo_on(fifo_on), .dma_sel(dma_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
        #1;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        d = rx_head;
        host_rd_data = 1'b1;
        @(negedge clk);
        host_rd_data = 1'b0;
        #1;
    endtask

    task automatic read_lsr();
        @(negedge clk);
        host_rd_lsr = 1'b1;
        @(negedge clk);
        host_rd_lsr = 1'b0;
        #1;
    endtask

    task automatic ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_byte = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        #1;
    endtask

    function automatic int lvl(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    // R1: reset state
    task automatic t_reset();
        check("R1 lsr", {24'h0, rx_lsr}, 32'h0);
        check("R1 trig", {31'h0, rx_trig}, 32'h0);
        check("R1 flush/on/dma", {29'h0, tx_flush, fifo_on, dma_sel}, 32'h0);
    endtask

    // R2, R3, R4: fill to 16, overrun on the 17th, drain in order
    task automatic t_full();
        logic [7:0] d;
        ctl(8'h03);
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        check("R3 no overrun at 16", {31'h0, rx_lsr[1]}, 32'h0);
        push(8'hEE, 1'b0, 1'b0, 1'b0);
        check("R3 overrun on 17th", {31'h0, rx_lsr[1]}, 32'h1);
        check("R2 head oldest", {24'h0, rx_head}, 32'h40);
        for (int i = 0; i < 16; i++) begin
            pop(d);
            check("R2 R3 order kept", {24'h0, d}, 32'h40 + i);
        end
        check("R2 empty after drain", {31'h0, rx_lsr[0]}, 32'h0);
        check("R4 overrun held", {31'h0, rx_lsr[1]}, 32'h1);
        read_lsr();
        check("R4 overrun cleared", {31'h0, rx_lsr[1]}, 32'h0);
    endtask

    // R5: each threshold code
    task automatic t_trig();
        for (int c = 0; c < 4; c++) begin
            ctl(8'(c << 6) | 8'h03);
            check("R5 trig empty", {31'h0, rx_trig}, 32'h0);
            for (int n = 1; n <= 14; n++) begin
                push(8'(n), 1'b0, 1'b0, 1'b0);
                check("R5 trig level", {31'h0, rx_trig}, (n >= lvl(c)) ? 32'h1 : 32'h0);
            end
        end
    endtask

    // R6 and R7: one-shot clear bits
    task automatic t_clear();
        ctl(8'h83);
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i), 1'b0, 1'b0, 1'b0);
        check("R6 trig before clear", {31'h0, rx_trig}, 32'h1);
        ctl(8'h83);
        check("R6 cleared", {30'h0, rx_lsr[0], rx_trig}, 32'h0);
        for (int i = 0; i < 8; i++) push(8'h20 + 8'(i), 1'b0, 1'b0, 1'b0);
        ctl(8'h81);
        check("R6 no repeat clear", {30'h0, rx_lsr[0], rx_trig}, 32'h3);
        ctl(8'h85);
        check("R7 flush pulse", {31'h0, tx_flush}, 32'h1);
        check("R7 rx untouched", {24'h0, rx_head}, 32'h20);
        @(negedge clk); #1;
        check("R7 flush one cycle", {31'h0, tx_flush}, 32'h0);
    endtask

    // R8 and R9: head marks and error summary
    task automatic t_err();
        logic [7:0] d;
        ctl(8'h03);
        read_lsr();
        push(8'hA1, 1'b1, 1'b0, 1'b0);
        push(8'hA2, 1'b0, 1'b1, 1'b0);
        push(8'hA3, 1'b0, 1'b0, 1'b1);
        push(8'hA4, 1'b0, 1'b0, 1'b0);
        check("R8 parity at head", {29'h0, rx_lsr[4:2]}, 32'h1);
        check("R9 summary set", {31'h0, rx_lsr[7]}, 32'h1);
        pop(d);
        check("R8 framing at head", {29'h0, rx_lsr[4:2]}, 32'h2);
        pop(d);
        check("R8 break at head", {29'h0, rx_lsr[4:2]}, 32'h4);
        read_lsr();
        check("R9 kept while marked stored", {31'h0, rx_lsr[7]}, 32'h1);
        pop(d);
        check("R8 clean head", {29'h0, rx_lsr[4:2]}, 32'h0);
        check("R9 held until status read", {31'h0, rx_lsr[7]}, 32'h1);
        read_lsr();
        check("R9 cleared by read", {31'h0, rx_lsr[7]}, 32'h0);
        pop(d);
        check("R8 empty zero", {29'h0, rx_lsr[4:2]}, 32'h0);
    endtask

    // R10, R11, R12: single-register mode, enable toggle, DMA select
    task automatic t_single();
        logic [7:0] d;
        ctl(8'h09);
        check("R12 dma on", {31'h0, dma_sel}, 32'h1);
        ctl(8'hC8);
        check("R11 fifo off", {31'h0, fifo_on}, 32'h0);
        check("R12 dma off when disabled", {31'h0, dma_sel}, 32'h0);
        push(8'h5A, 1'b0, 1'b0, 1'b0);
        check("R10 trig equals ready", {30'h0, rx_lsr[0], rx_trig}, 32'h3);
        push(8'h5B, 1'b0, 1'b0, 1'b0);
        check("R10 second overruns", {31'h0, rx_lsr[1]}, 32'h1);
        pop(d);
        check("R10 first kept", {24'h0, d}, 32'h5A);
        check("R10 single slot empty", {31'h0, rx_lsr[0]}, 32'h0);
        push(8'h5C, 1'b0, 1'b0, 1'b0);
        ctl(8'h01);
        check("R11 toggle clears rx", {31'h0, rx_lsr[0]}, 32'h0);
        check("R11 toggle flushes tx", {31'h0, tx_flush}, 32'h1);
        check("R11 fifo on", {31'h0, fifo_on}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_full();
        t_trig();
        t_clear();
        t_err();
        t_single();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule